// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter whose configuration can be changed only through a two-step key handshake on a simple register port. Software first writes one magic value to a first key register and then a second magic value to a second key register. After that it may make exactly one write to a guarded register. Any further guarded write needs a new key pair.

The guarded registers are the fire threshold, the control bits (count enable and reset enable), the status flag and an acknowledge register. While counting is enabled and no event is pending, the counter advances once per clock. When it reaches the threshold, the block raises the status flag, which also drives the interrupt line, and restarts the count from zero. It then holds until software clears the flag. If reset generation is enabled, a single-cycle reset pulse goes out at the same moment. Passing that pulse on to the rest of the chip is left to logic outside the block.

The gate is a three-state machine. LOCKED moves to HALF_OPEN on a correct first-key write (transition KEY1_MATCH). HALF_OPEN moves to OPEN on a correct second-key write (transition KEY2_MATCH). HALF_OPEN falls back to LOCKED on any other write (transition ABORT). OPEN returns to LOCKED on the next write of any kind, and that write is accepted if it targets a guarded register (transition CONSUME). LOCKED stays LOCKED on every other write (transition HOLD). Reads never move the machine.

Top module: `wdg_keyed_top`

## Requirements
- R1: After reset the gate is LOCKED, the control bits are 0, the status flag is 0, the count is 0, the threshold reads 0xFFFFFFFF, and both the reset pulse and the interrupt are low.
- R2: A write of 0x0000BABA to the first key register (index 0), followed directly by a write of 0x0000EB10 to the second key register (index 1), opens the gate, and the next write to a guarded register takes effect.
- R3: Only one write is accepted per opening. Any write made while the gate is OPEN returns it to LOCKED, so a second guarded write without a new key pair is ignored.
- R4: A wrong key value, the keys in reverse order, or any other write between the two keys leaves the gate LOCKED, and a guarded write that follows is ignored.
- R5: A guarded write made while the gate is not OPEN leaves the register unchanged, as seen on read-back.
- R6: The control register (index 3) holds bit 0, which enables counting, and bit 1, which enables the reset pulse. It reads back in bits [1:0].
- R7: While bit 0 of the control register is set and the status flag is clear, the count (read at index 6) rises by one per clock. It holds while counting is disabled.
- R8: When the count is at or above the threshold (index 2, 32 bits, read back in full) while counting is enabled and the flag is clear, the next clock sets the status flag and zeroes the count. The interrupt output follows the flag, and counting stays frozen while the flag is set.
- R9: The reset pulse is high for exactly one cycle, in the same cycle the status flag rises, and only if bit 1 of the control register was set.
- R10: The status flag reads at index 4, bit 0. A granted write to index 4 with bit 0 = 0 clears it, and writing 1 there has no effect. A granted write to index 5 with bit 0 = 1 also clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wd_rst_pulse | output | 1 | Single-cycle reset request |
| wd_irq | output | 1 | Level interrupt, equal to the status flag |

## Verification
If the gate state goes wrong, the evidence shows up one read later: the guarded register read back at its index keeps its old value, or takes a value it should not have. If the counter or the comparator goes wrong, the count read back drifts from the expected one cycle per clock within a single cycle. A wrong comparison also moves the rise of the interrupt and of the reset pulse away from the clock in which the count reaches the threshold, so the outputs are compared against a cycle-level reference model on every clock.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] IDX_KEY1  = 3'd0;
    localparam logic [ADDR_W-1:0] IDX_KEY2  = 3'd1;
    localparam logic [ADDR_W-1:0] IDX_LIMIT = 3'd2;
    localparam logic [ADDR_W-1:0] IDX_CTRL  = 3'd3;
    localparam logic [ADDR_W-1:0] IDX_FLAG  = 3'd4;
    localparam logic [ADDR_W-1:0] IDX_ACK   = 3'd5;
    localparam logic [ADDR_W-1:0] IDX_COUNT = 3'd6;

    typedef enum logic [1:0] {
        LK_LOCKED    = 2'd0,
        LK_HALF_OPEN = 2'd1,
        LK_OPEN      = 2'd2
    } lock_state_t;

    typedef struct packed {
        logic rst_en;
        logic cnt_en;
    } wdg_ctrl_t;

endpackage

// File: rtl/wdg_unlock_fsm.sv
module wdg_unlock_fsm
    import wdg_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter logic [15:0] KEY1   = 16'hBABA,
    parameter logic [15:0] KEY2   = 16'hEB10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_stb,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output lock_state_t          state_q,
    output logic                 grant
);

    localparam logic [DATA_W-1:0] KEY1_W = DATA_W'(KEY1);
    localparam logic [DATA_W-1:0] KEY2_W = DATA_W'(KEY2);

    lock_state_t state_d;
    logic        key1_hit;
    logic        key2_hit;

    assign key1_hit = (wr_addr == IDX_KEY1) && (wr_data == KEY1_W);
    assign key2_hit = (wr_addr == IDX_KEY2) && (wr_data == KEY2_W);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: every write moves the machine, reads never do
    always_comb begin
        state_d = state_q;
        if (wr_stb) begin
            unique case (state_q)
                LK_LOCKED:    state_d = key1_hit ? LK_HALF_OPEN : LK_LOCKED;
                LK_HALF_OPEN: state_d = key2_hit ? LK_OPEN : LK_LOCKED;
                LK_OPEN:      state_d = LK_LOCKED;
                default:      state_d = LK_LOCKED;
            endcase
        end
    end

    // Outputs: a write is granted only while the gate is open
    always_comb begin
        grant = 1'b0;
        unique case (state_q)
            LK_OPEN:      grant = wr_stb;
            LK_LOCKED,
            LK_HALF_OPEN: grant = 1'b0;
            default:      grant = 1'b0;
        endcase
    end

endmodule

// File: rtl/wdg_prot_regs.sv
module wdg_prot_regs
    import wdg_pkg::*;
#(
    parameter int               DATA_W    = 32,
    parameter int               CNT_W     = 32,
    parameter logic [CNT_W-1:0] LIMIT_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  limit_q,
    output wdg_ctrl_t         ctrl_q,
    output logic              clr_req
);

    logic wr_limit;
    logic wr_ctrl;

    assign wr_limit = grant && (wr_addr == IDX_LIMIT);
    assign wr_ctrl  = grant && (wr_addr == IDX_CTRL);

    // Status clear: zero in bit 0 at the flag index, or one at the ack index
    always_comb begin
        clr_req = 1'b0;
        if (grant) begin
            if (wr_addr == IDX_FLAG) begin
                clr_req = ~wr_data[0];
            end else if (wr_addr == IDX_ACK) begin
                clr_req = wr_data[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q <= LIMIT_RST;
            ctrl_q  <= '0;
        end else begin
            if (wr_limit) begin
                limit_q <= wr_data[CNT_W-1:0];
            end
            if (wr_ctrl) begin
                ctrl_q <= wdg_ctrl_t'(wr_data[1:0]);
            end
        end
    end

endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wdg_ctrl_t        ctrl,
    input  logic [CNT_W-1:0] limit,
    input  logic             clr_req,
    output logic [CNT_W-1:0] count_q,
    output logic             status_q,
    output logic             pulse_q
);

    logic running;
    logic hit;

    assign running = ctrl.cnt_en && !status_q;
    assign hit     = running && (count_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            status_q <= 1'b0;
            pulse_q  <= 1'b0;
        end else begin
            pulse_q <= hit && ctrl.rst_en;
            if (hit) begin
                count_q  <= '0;
                status_q <= 1'b1;
            end else begin
                if (running) begin
                    count_q <= count_q + CNT_W'(1);
                end
                if (clr_req) begin
                    status_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/wdg_keyed_top.sv
module wdg_keyed_top
    import wdg_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter int          CNT_W  = 32,
    parameter logic [15:0] KEY1   = 16'hBABA,
    parameter logic [15:0] KEY2   = 16'hEB10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wd_rst_pulse,
    output logic              wd_irq
);

    lock_state_t      lk_state;
    logic             grant;
    logic [CNT_W-1:0] limit_q;
    wdg_ctrl_t        ctrl_q;
    logic             clr_req;
    logic [CNT_W-1:0] count_q;
    logic             status_q;

    wdg_unlock_fsm #(
        .DATA_W (DATA_W),
        .KEY1   (KEY1),
        .KEY2   (KEY2)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (bus_we),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .state_q (lk_state),
        .grant   (grant)
    );

    wdg_prot_regs #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .grant   (grant),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .limit_q (limit_q),
        .ctrl_q  (ctrl_q),
        .clr_req (clr_req)
    );

    wdg_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl_q),
        .limit    (limit_q),
        .clr_req  (clr_req),
        .count_q  (count_q),
        .status_q (status_q),
        .pulse_q  (wd_rst_pulse)
    );

    assign wd_irq = status_q;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            IDX_LIMIT: bus_rdata = DATA_W'(limit_q);
            IDX_CTRL:  bus_rdata = DATA_W'(ctrl_q);
            IDX_FLAG:  bus_rdata = DATA_W'(status_q);
            IDX_COUNT: bus_rdata = DATA_W'(count_q);
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdg_keyed_chk.sv
module wdg_keyed_chk
    import wdg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [2:0]       bus_addr,
    input lock_state_t      lk_state,
    input logic [CNT_W-1:0] limit_q,
    input wdg_ctrl_t        ctrl_q,
    input logic             status_q,
    input logic [CNT_W-1:0] count_q,
    input logic             wd_rst_pulse
);

    // R3
    open_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_state == LK_OPEN && bus_we) |=> (lk_state == LK_LOCKED));

    // R4
    half_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_state == LK_HALF_OPEN && bus_we && bus_addr != IDX_KEY2) |=> (lk_state == LK_LOCKED));

    // R5
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_state != LK_OPEN) |=> ($stable(limit_q) && $stable(ctrl_q)));

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.cnt_en && !status_q && count_q < limit_q) |=> (count_q == $past(count_q) + CNT_W'(1)));

    // R8
    frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_q |=> $stable(count_q));

    // R9
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_pulse |=> !wd_rst_pulse);

    // R9
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_pulse |-> ($rose(status_q) && $past(ctrl_q.rst_en)));

endmodule

bind wdg_keyed_top wdg_keyed_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .lk_state     (lk_state),
    .limit_q      (limit_q),
    .ctrl_q       (ctrl_q),
    .status_q     (status_q),
    .count_q      (count_q),
    .wd_rst_pulse (wd_rst_pulse)
);

// File: tb/wdg_keyed_top_tb.sv
module wdg_keyed_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wd_rst_pulse;
    logic        wd_irq;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic [31:0] last_rd;

    // reference model state
    int          m_state = 0;
    logic [31:0] m_limit = 32'hFFFF_FFFF;
    logic [1:0]  m_ctrl = 2'b00;
    logic        m_status = 1'b0;
    logic [31:0] m_count = '0;
    logic        m_pulse = 1'b0;

    always #5 clk = ~clk;

    wdg_keyed_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .wd_rst_pulse (wd_rst_pulse),
        .wd_irq       (wd_irq)
    );

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd2:    return m_limit;
            3'd3:    return {30'b0, m_ctrl};
            3'd4:    return {31'b0, m_status};
            3'd6:    return m_count;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [2:0] a);
        case (a)
            3'd2:    return "R8 threshold readback";
            3'd3:    return "R6";
            3'd4:    return "R10";
            3'd6:    return "R7";
            default: return "R5 unmapped read";
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_update(input logic we, input logic [2:0] a, input logic [31:0] d);
        logic        ok;
        logic        hit;
        int          ns;
        logic [31:0] nc;
        logic        nst;
        ok  = we && (m_state == 2);
        hit = m_ctrl[0] && !m_status && (m_count >= m_limit);
        ns  = m_state;
        if (we) begin
            case (m_state)
                0:       ns = (a == 3'd0 && d == 32'h0000BABA) ? 1 : 0;
                1:       ns = (a == 3'd1 && d == 32'h0000EB10) ? 2 : 0;
                default: ns = 0;
            endcase
        end
        nc  = m_count;
        nst = m_status;
        if (hit) begin
            nc  = '0;
            nst = 1'b1;
        end else begin
            if (m_ctrl[0] && !m_status) nc = m_count + 1;
            if (ok && a == 3'd4 && !d[0]) nst = 1'b0;
            if (ok && a == 3'd5 && d[0])  nst = 1'b0;
        end
        m_pulse  = hit && m_ctrl[1];
        if (ok && a == 3'd2) m_limit = d;
        if (ok && a == 3'd3) m_ctrl = d[1:0];
        m_state  = ns;
        m_count  = nc;
        m_status = nst;
    endtask

    task automatic step(input logic we, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        chk({31'b0, wd_rst_pulse}, {31'b0, m_pulse}, "R9 reset pulse");
        chk({31'b0, wd_irq}, {31'b0, m_status}, "R8 interrupt");
        if (wd_rst_pulse) pulses++;
        bus_we    = we;
        bus_addr  = a;
        bus_wdata = d;
        #1;
        if (!we) begin
            last_rd = bus_rdata;
            chk(bus_rdata, model_read(a), read_tag(a));
        end
        @(posedge clk);
        model_update(we, a, d);
    endtask

    task automatic unlock();
        step(1'b1, 3'd0, 32'h0000BABA);
        step(1'b1, 3'd1, 32'h0000EB10);
    endtask

    task automatic gwrite(input logic [2:0] a, input logic [31:0] d);
        unlock();
        step(1'b1, a, d);
    endtask

    task automatic rd(input logic [2:0] a);
        step(1'b0, a, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd2); chk(last_rd, 32'hFFFF_FFFF, "R1 threshold");
        rd(3'd3); chk(last_rd, 32'h0, "R1 control");
        rd(3'd4); chk(last_rd, 32'h0, "R1 flag");
        rd(3'd6); chk(last_rd, 32'h0, "R1 count");

        // R2 proper unlock
        gwrite(3'd2, 32'h0000_0005);
        rd(3'd2); chk(last_rd, 32'h5, "R2 granted write");

        // R3 second write without keys
        step(1'b1, 3'd2, 32'h0000_0009);
        rd(3'd2); chk(last_rd, 32'h5, "R3 single write per unlock");

        // R5 locked write
        step(1'b1, 3'd3, 32'h3);
        rd(3'd3); chk(last_rd, 32'h0, "R5 locked control write");

        // R4 wrong key
        step(1'b1, 3'd0, 32'h0000BABB);
        step(1'b1, 3'd1, 32'h0000EB10);
        step(1'b1, 3'd2, 32'h7);
        rd(3'd2); chk(last_rd, 32'h5, "R4 wrong key");
        // R4 reversed order
        step(1'b1, 3'd1, 32'h0000EB10);
        step(1'b1, 3'd0, 32'h0000BABA);
        step(1'b1, 3'd2, 32'h7);
        rd(3'd2); chk(last_rd, 32'h5, "R4 reversed keys");
        // R4 intervening write
        step(1'b1, 3'd0, 32'h0000BABA);
        step(1'b1, 3'd6, 32'h0);
        step(1'b1, 3'd1, 32'h0000EB10);
        step(1'b1, 3'd2, 32'h7);
        rd(3'd2); chk(last_rd, 32'h5, "R4 intervening write");

        // R6 / R7 / R8 / R9 fire with reset enabled
        gwrite(3'd2, 32'h4);
        pulses = 0;
        gwrite(3'd3, 32'h3);
        rd(3'd3); chk(last_rd, 32'h3, "R6 control readback");
        repeat (12) rd(3'd6);
        chk({31'b0, wd_irq}, 32'h1, "R8 flag set after threshold");
        chk(pulses, 1, "R9 exactly one pulse");
        rd(3'd6); chk(last_rd, 32'h0, "R8 count frozen at zero");

        // R10 writing one to flag index does not clear
        gwrite(3'd4, 32'h1);
        rd(3'd4); chk(last_rd, 32'h1, "R10 write one keeps flag");
        // R10 clear through flag index
        gwrite(3'd4, 32'h0);
        rd(3'd4); chk(last_rd, 32'h0, "R10 flag cleared");
        repeat (8) rd(3'd6);
        // R10 clear through ack index
        gwrite(3'd5, 32'h1);
        rd(3'd4); chk(last_rd, 32'h0, "R10 ack clear");

        // R9 no pulse when reset generation disabled
        pulses = 0;
        gwrite(3'd3, 32'h1);
        repeat (12) rd(3'd4);
        chk(pulses, 0, "R9 pulse suppressed");

        // R7 counting halts when disabled
        gwrite(3'd5, 32'h1);
        gwrite(3'd3, 32'h0);
        rd(3'd6);
        rd(3'd6); chk(last_rd, model_read(3'd6), "R7 hold while disabled");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int sel;
            sel = $urandom_range(0, 9);
            if (sel < 5) begin
                rd(3'($urandom_range(0, 7)));
            end else if (sel < 8) begin
                logic [2:0] a;
                logic [31:0] d;
                a = 3'($urandom_range(2, 5));
                d = (a == 3'd2) ? 32'($urandom_range(0, 40)) : 32'($urandom);
                if ($urandom_range(0, 3) == 0) step(1'b1, a, d);
                else gwrite(a, d);
            end else begin
                logic [31:0] d;
                d = ($urandom_range(0, 1) == 0) ? 32'h0000BABA : 32'($urandom);
                step(1'b1, 3'($urandom_range(0, 7)), d);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule